// File: doc/BRIEF.md
# Fabric Configuration Sequencer

This block sits on a register bus and steps an attached programmable fabric through its configuration sequence. Software drives it through six word-addressed registers: a status word, a control word, a data-clock count, a data-clock done flag, a latched monitor-event word and the live monitor lines. A separate write-only data port takes 32-bit configuration words and forwards them to the fabric while the sequence is in its configuration phase.

A state machine tracks where the fabric is. It starts powered off. A reset request moves it to the reset phase, and releasing the request moves it to the configuration phase. Once enough words have been taken, the configuration is marked complete. Extra data clocks, issued by a programmable pulse counter, then move the fabric into its init phase and from there into user mode. Strap pins are decoded at reset into a default clock-to-data ratio and a default data width in the control word.

No fabric is attached in this block. Completion is raised by an internal counter of accepted words, and an error input stands in for the fabric pulling its status line low.

Top module: `cfg_fabric_ctrl`

## Requirements
- R1: After reset the mode field (status bits [2:0]) reads 0 (off). Status bits [7:3] show the strap pins. The control word reads with bit 1 (chip enable, active low) set, bits [7:6] holding the decoded ratio, bit 9 holding the decoded width, and every other bit 0.
- R2: The width bit is strap bit 3. The ratio code is taken from (strap AND 0xB): 0xA gives 3 (x8), 0x2 or 0x9 gives 2 (x4), 0x1 gives 1 (x2), and any other value gives 0 (x1). Strap bits 2 and 4 have no effect.
- R3: With control bit 0 (drive) set, setting control bit 2 (reset request) moves the mode to 1 (reset phase). Clearing bit 2 then moves the mode to 2 (configuration phase).
- R4: A data-port write is accepted only while control bit 8 is set and the mode is 2. An accepted word appears on fab_data_o, with fab_data_vld_o high, one cycle later. Any other data-port write is dropped and sets the sticky drop_err_o, which also reads as status bit 8.
- R5: After WORDS_TO_DONE accepted words, monitor register bits [1:0] read 1 (done, status good) and mon_done_o is high.
- R6: If fab_err_i is seen in mode 2 before completion, monitor bit 0 reads 0, mon_err_o goes high and the mode becomes 5 (unknown).
- R7: Writing N to the count register (offset 2) produces N data-clock pulses on fab_dclk_o. Each pulse is one cycle high and is followed by a low cycle. When the count runs out, the done register (offset 3) reads 1. Writing 1 to offset 3 clears it.
- R8: From mode 2 with configuration complete, INIT_CLKS data clocks move the mode to 3 (init). USER_CLKS further data clocks move it to 4 (user), and monitor bit 2 then reads 1.
- R9: While control bit 0 is clear, fab_pull_o is 0, fab_ce_n_o is 1, fab_dclk_o stays low, and the mode does not change.
- R10: A rising edge on any monitor bit [3:0] sets the matching bit of the event register (offset 4) and raises irq_o. Writing ones to offset 4 clears the matching bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Register word index |
| bus_wdata_i | input | DATA_W | Register write data |
| bus_rdata_o | output | DATA_W | Register read data, valid the cycle after the read strobe |
| dat_wr_i | input | 1 | Configuration data write strobe |
| dat_i | input | DATA_W | Configuration data word |
| strap_i | input | STRAP_W | Strap pins |
| fab_err_i | input | 1 | Fabric reports a configuration fault |
| crc_err_i | input | 1 | Fabric reports a checksum fault |
| fab_pull_o | output | 1 | Reset request line to the fabric |
| fab_ce_n_o | output | 1 | Active-low fabric chip enable |
| fab_dclk_o | output | 1 | Extra data-clock pulses |
| fab_data_o | output | DATA_W | Forwarded configuration word |
| fab_data_vld_o | output | 1 | Forwarded word valid |
| fab_wide_o | output | 1 | Selected wide data width |
| fab_ratio_o | output | 2 | Selected clock-to-data ratio code |
| mon_done_o | output | 1 | Configuration complete without error |
| mon_err_o | output | 1 | Configuration error |
| drop_err_o | output | 1 | Sticky flag for a dropped data write |
| irq_o | output | 1 | Any latched monitor event pending |

## Verification
The hardest states to reach are init phase and user mode. Getting there needs the full chain: a reset request, a release, exactly WORDS_TO_DONE accepted words, and then two programmed pulse runs, the second of which takes more than forty thousand cycles. The bench walks that chain in order. Partway through, it turns the drive bit off and issues pulses that must neither appear nor count, and only then finishes the climb to user mode. The error mode comes last: a new reset request restarts the sequence, the word counter is empty, and an injected fault then sends the fabric to the unknown mode.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;

  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_RST  = 3'd1,
    MODE_CFG  = 3'd2,
    MODE_INIT = 3'd3,
    MODE_USER = 3'd4,
    MODE_UNK  = 3'd5
  } fab_mode_e;

  // register word indices
  localparam int unsigned REG_STATUS = 0;
  localparam int unsigned REG_CTRL   = 1;
  localparam int unsigned REG_DCNT   = 2;
  localparam int unsigned REG_DDONE  = 3;
  localparam int unsigned REG_IRQ    = 4;
  localparam int unsigned REG_MON    = 5;

  // control word bit positions
  localparam int unsigned CB_DRIVE = 0;
  localparam int unsigned CB_CEN   = 1;
  localparam int unsigned CB_PULL  = 2;
  localparam int unsigned CB_RATIO = 6;
  localparam int unsigned CB_BUS   = 8;
  localparam int unsigned CB_WIDE  = 9;

  localparam logic [1:0] RATIO_X1 = 2'd0;
  localparam logic [1:0] RATIO_X2 = 2'd1;
  localparam logic [1:0] RATIO_X4 = 2'd2;
  localparam logic [1:0] RATIO_X8 = 2'd3;

endpackage

// File: rtl/cfgm_strap_decode.sv
module cfgm_strap_decode
  import cfgm_pkg::*;
(
  input  logic [3:0] strap_i,
  output logic [1:0] ratio_o,
  output logic       wide_o
);

  logic [3:0] key;

  assign key    = strap_i & 4'hB;
  assign wide_o = strap_i[3];

  always_comb begin
    case (key)
      4'hA:       ratio_o = RATIO_X8;
      4'h2, 4'h9: ratio_o = RATIO_X4;
      4'h1:       ratio_o = RATIO_X2;
      default:    ratio_o = RATIO_X1;
    endcase
  end

endmodule

// File: rtl/cfgm_dclk_gen.sv
module cfgm_dclk_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             clr_i,
  output logic             pulse_o,
  output logic             done_o
);

  logic [CNT_W-1:0] remain_q;
  logic             phase_q;
  logic             pulse_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      phase_q  <= 1'b0;
      pulse_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (load_i) begin
        remain_q <= cnt_i;
        phase_q  <= 1'b0;
        done_q   <= (cnt_i == '0);
      end else begin
        if (clr_i) done_q <= 1'b0;
        if (remain_q != '0) begin
          if (!phase_q) begin
            pulse_q <= en_i;
            phase_q <= 1'b1;
          end else begin
            phase_q  <= 1'b0;
            remain_q <= remain_q - 1'b1;
            if (remain_q == CNT_W'(1)) done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign pulse_o = pulse_q;
  assign done_o  = done_q;

  // R7
  pulse_gap_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);

  // R7
  load_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && cnt_i != '0) |=> !done_q);

endmodule

// File: rtl/cfgm_mode_fsm.sv
module cfgm_mode_fsm
  import cfgm_pkg::*;
#(
  parameter int INIT_CLKS = 4,
  parameter int USER_CLKS = 20480
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      drive_en_i,
  input  logic      pull_i,
  input  logic      conf_done_i,
  input  logic      status_ok_i,
  input  logic      dclk_i,
  output fab_mode_e mode_o
);

  localparam int MAX_CLKS = (USER_CLKS > INIT_CLKS) ? USER_CLKS : INIT_CLKS;
  localparam int PC_W     = $clog2(MAX_CLKS + 1);

  fab_mode_e       mode_q;
  logic [PC_W-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_OFF;
      pcnt_q <= '0;
    end else if (drive_en_i) begin
      if (pull_i) begin
        mode_q <= MODE_RST;
        pcnt_q <= '0;
      end else begin
        case (mode_q)
          MODE_RST: mode_q <= MODE_CFG;
          MODE_CFG: begin
            if (!status_ok_i && !conf_done_i) begin
              mode_q <= MODE_UNK;
            end else if (conf_done_i && dclk_i) begin
              if (pcnt_q == PC_W'(INIT_CLKS - 1)) begin
                mode_q <= MODE_INIT;
                pcnt_q <= '0;
              end else begin
                pcnt_q <= pcnt_q + 1'b1;
              end
            end
          end
          MODE_INIT: begin
            if (dclk_i) begin
              if (pcnt_q == PC_W'(USER_CLKS - 1)) begin
                mode_q <= MODE_USER;
                pcnt_q <= '0;
              end else begin
                pcnt_q <= pcnt_q + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign mode_o = mode_q;

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !drive_en_i |=> $stable(mode_q));

  // R3
  release_to_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (drive_en_i && !pull_i && mode_q == MODE_RST) |=> mode_q == MODE_CFG);

  // R3
  pull_to_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (drive_en_i && pull_i) |=> mode_q == MODE_RST);

endmodule

// File: rtl/cfg_fabric_ctrl.sv
module cfg_fabric_ctrl
  import cfgm_pkg::*;
#(
  parameter int ADDR_W        = 3,
  parameter int DATA_W        = 32,
  parameter int CNT_W         = 16,
  parameter int STRAP_W       = 5,
  parameter int WORDS_TO_DONE = 8,
  parameter int INIT_CLKS     = 4,
  parameter int USER_CLKS     = 20480
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic               dat_wr_i,
  input  logic [DATA_W-1:0]  dat_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               fab_err_i,
  input  logic               crc_err_i,
  output logic               fab_pull_o,
  output logic               fab_ce_n_o,
  output logic               fab_dclk_o,
  output logic [DATA_W-1:0]  fab_data_o,
  output logic               fab_data_vld_o,
  output logic               fab_wide_o,
  output logic [1:0]         fab_ratio_o,
  output logic               mon_done_o,
  output logic               mon_err_o,
  output logic               drop_err_o,
  output logic               irq_o
);

  localparam int WC_W  = $clog2(WORDS_TO_DONE + 1);
  localparam int MON_W = 4;

  // control fields
  logic       drive_q, cen_q, pull_q, bus_q, wide_q;
  logic [1:0] ratio_q;
  logic [1:0] dec_ratio;
  logic       dec_wide;

  logic [WC_W-1:0]  wcnt_q;
  logic             err_lat_q;
  logic             drop_q;
  logic [MON_W-1:0] mon_q, mon_prev_q, irq_q;
  logic             conf_done, status_ok, accept;
  logic             wr_ctrl, wr_dcnt, wr_ddone, wr_irq;
  logic             dclk_pulse, dclk_done;
  logic [DATA_W-1:0] ctrl_word;
  fab_mode_e        mode;
  logic             unused_bits;

  assign unused_bits = ^bus_wdata_i[DATA_W-1:CNT_W];

  cfgm_strap_decode u_strap (
    .strap_i (strap_i[3:0]),
    .ratio_o (dec_ratio),
    .wide_o  (dec_wide)
  );

  assign wr_ctrl  = bus_wr_i && bus_addr_i == ADDR_W'(REG_CTRL);
  assign wr_dcnt  = bus_wr_i && bus_addr_i == ADDR_W'(REG_DCNT);
  assign wr_ddone = bus_wr_i && bus_addr_i == ADDR_W'(REG_DDONE);
  assign wr_irq   = bus_wr_i && bus_addr_i == ADDR_W'(REG_IRQ);

  // control register, defaults taken from straps at reset
  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
      cen_q   <= 1'b1;
      pull_q  <= 1'b0;
      ratio_q <= dec_ratio;
      bus_q   <= 1'b0;
      wide_q  <= dec_wide;
    end else if (wr_ctrl) begin
      drive_q <= bus_wdata_i[CB_DRIVE];
      cen_q   <= bus_wdata_i[CB_CEN];
      pull_q  <= bus_wdata_i[CB_PULL];
      ratio_q <= bus_wdata_i[CB_RATIO +: 2];
      bus_q   <= bus_wdata_i[CB_BUS];
      wide_q  <= bus_wdata_i[CB_WIDE];
    end
  end

  assign ctrl_word = DATA_W'({wide_q, bus_q, ratio_q, 3'b000, pull_q, cen_q, drive_q});

  cfgm_dclk_gen #(.CNT_W(CNT_W)) u_dclk (
    .clk     (clk),
    .rst     (rst),
    .en_i    (drive_q),
    .load_i  (wr_dcnt),
    .cnt_i   (bus_wdata_i[CNT_W-1:0]),
    .clr_i   (wr_ddone && bus_wdata_i[0]),
    .pulse_o (dclk_pulse),
    .done_o  (dclk_done)
  );

  cfgm_mode_fsm #(.INIT_CLKS(INIT_CLKS), .USER_CLKS(USER_CLKS)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .drive_en_i  (drive_q),
    .pull_i      (pull_q),
    .conf_done_i (conf_done),
    .status_ok_i (status_ok),
    .dclk_i      (dclk_pulse),
    .mode_o      (mode)
  );

  assign conf_done = (wcnt_q == WC_W'(WORDS_TO_DONE));
  assign status_ok = !err_lat_q;
  assign accept    = dat_wr_i && bus_q && (mode == MODE_CFG);

  // data path, word counter, fault latch, drop flag
  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q         <= '0;
      err_lat_q      <= 1'b0;
      drop_q         <= 1'b0;
      fab_data_o     <= '0;
      fab_data_vld_o <= 1'b0;
    end else begin
      fab_data_vld_o <= accept;
      if (accept) fab_data_o <= dat_i;
      if (dat_wr_i && !accept) drop_q <= 1'b1;
      if (mode == MODE_RST) begin
        wcnt_q    <= '0;
        err_lat_q <= 1'b0;
      end else begin
        if (accept && !conf_done) wcnt_q <= wcnt_q + 1'b1;
        if (fab_err_i && mode == MODE_CFG) err_lat_q <= 1'b1;
      end
    end
  end

  // monitor lines and latched events
  always_ff @(posedge clk) begin
    if (rst) begin
      mon_q      <= 4'b0001;
      mon_prev_q <= 4'b0001;
      irq_q      <= '0;
      mon_done_o <= 1'b0;
      mon_err_o  <= 1'b0;
    end else begin
      mon_q      <= {crc_err_i, mode == MODE_USER, conf_done, status_ok};
      mon_prev_q <= mon_q;
      irq_q      <= (irq_q & ~(wr_irq ? bus_wdata_i[MON_W-1:0] : '0))
                    | (mon_q & ~mon_prev_q);
      mon_done_o <= status_ok && conf_done;
      mon_err_o  <= !status_ok && !conf_done;
    end
  end

  // configuration line outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      fab_pull_o <= 1'b0;
      fab_ce_n_o <= 1'b1;
    end else begin
      fab_pull_o <= drive_q && pull_q;
      fab_ce_n_o <= !drive_q || cen_q;
    end
  end

  assign fab_dclk_o  = dclk_pulse;
  assign fab_wide_o  = wide_q;
  assign fab_ratio_o = ratio_q;
  assign drop_err_o  = drop_q;
  assign irq_o       = |irq_q;

  // read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
    end else if (bus_rd_i) begin
      case (bus_addr_i)
        ADDR_W'(REG_STATUS): bus_rdata_o <= DATA_W'({drop_q, strap_i, 3'(mode)});
        ADDR_W'(REG_CTRL):   bus_rdata_o <= ctrl_word;
        ADDR_W'(REG_DDONE):  bus_rdata_o <= DATA_W'(dclk_done);
        ADDR_W'(REG_IRQ):    bus_rdata_o <= DATA_W'(irq_q);
        ADDR_W'(REG_MON):    bus_rdata_o <= DATA_W'(mon_q);
        default:             bus_rdata_o <= '0;
      endcase
    end
  end

  // R4
  drop_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_wr_i && !(bus_q && mode == MODE_CFG)) |=> drop_err_o);

  // R4
  drop_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    drop_err_o |=> drop_err_o);

  // R9
  lines_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !drive_q |=> (!fab_pull_o && fab_ce_n_o && !fab_dclk_o));

  // R5
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mon_done_o && mon_err_o));

endmodule

// File: tb/cfg_fabric_ctrl_tb_top.sv
module cfg_fabric_ctrl_tb_top;

  localparam int WORDS = 8;
  localparam int UCLK  = 20480;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dat_wr = 1'b0;
  logic [31:0] dat = '0;
  logic [4:0]  strap = '0;
  logic        fab_err = 1'b0, crc_err = 1'b0;
  logic        fab_pull, fab_ce_n, fab_dclk, fab_data_vld, fab_wide;
  logic [31:0] fab_data;
  logic [1:0]  fab_ratio;
  logic        mon_done, mon_err, drop_err, irq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int pcount = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  cfg_fabric_ctrl dut_i (
    .clk(clk), .rst(rst),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .dat_wr_i(dat_wr), .dat_i(dat), .strap_i(strap),
    .fab_err_i(fab_err), .crc_err_i(crc_err),
    .fab_pull_o(fab_pull), .fab_ce_n_o(fab_ce_n), .fab_dclk_o(fab_dclk),
    .fab_data_o(fab_data), .fab_data_vld_o(fab_data_vld),
    .fab_wide_o(fab_wide), .fab_ratio_o(fab_ratio),
    .mon_done_o(mon_done), .mon_err_o(mon_err),
    .drop_err_o(drop_err), .irq_o(irq)
  );

  // strap vectors and the control word expected after reset (R1, R2)
  localparam logic [4:0]  TAB_STRAP [8] = '{5'h0A, 5'h02, 5'h09, 5'h01,
                                            5'h0B, 5'h16, 5'h1C, 5'h0E};
  localparam logic [31:0] TAB_CTRL  [8] = '{32'h2C2, 32'h082, 32'h282, 32'h042,
                                            32'h202, 32'h082, 32'h202, 32'h2C2};

  always @(negedge clk) if (fab_dclk === 1'b1) pcount++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    dat_wr = 1'b1; dat = w;
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  initial begin
    // table walk: reset defaults from straps
    for (int i = 0; i < 8; i++) begin
      strap = TAB_STRAP[i];
      do_reset();
      rd(3'd0, rv);
      chk("R1 status after reset", rv, {23'd0, 1'b0, TAB_STRAP[i], 3'd0});
      rd(3'd1, rv);
      chk("R2 control defaults from straps", rv, TAB_CTRL[i]);
    end

    strap = 5'h00;
    do_reset();
    chk("R1 lines idle after reset", {30'd0, fab_pull, fab_ce_n}, 32'h1);
    chk("R1 no drop flag after reset", {31'd0, drop_err}, 32'h0);

    // reset request
    wr(3'd1, 32'h5);
    rd(3'd0, rv);
    chk("R3 mode after reset request", rv & 32'h7, 32'd1);
    chk("R3 pull line driven", {30'd0, fab_pull, fab_ce_n}, 32'h2);

    // write outside configuration phase is dropped
    push(32'hDEAD0000);
    chk("R4 dropped word not forwarded", {31'd0, fab_data_vld}, 32'h0);
    chk("R4 drop flag set", {31'd0, drop_err}, 32'h1);

    wr(3'd1, 32'h1);
    rd(3'd0, rv);
    chk("R3 mode after release", rv & 32'h7, 32'd2);
    chk("R4 drop flag in status bit 8", (rv >> 8) & 32'h1, 32'h1);

    wr(3'd1, 32'h101);
    for (int i = 0; i < WORDS; i++) begin
      push(32'hA5000000 + i);
      chk("R4 word forwarded valid", {31'd0, fab_data_vld}, 32'h1);
      chk("R4 word forwarded value", fab_data, 32'hA5000000 + i);
    end
    repeat (3) @(negedge clk);
    rd(3'd5, rv);
    chk("R5 monitor after last word", rv, 32'h3);
    chk("R5 done output", {30'd0, mon_done, mon_err}, 32'h2);

    rd(3'd4, rv);
    chk("R10 event latched for done edge", rv, 32'h2);
    chk("R10 irq raised", {31'd0, irq}, 32'h1);
    wr(3'd4, 32'hFFF);
    rd(3'd4, rv);
    chk("R10 events cleared", rv, 32'h0);
    chk("R10 irq cleared", {31'd0, irq}, 32'h0);

    // four extra clocks
    pcount = 0;
    wr(3'd2, 32'd4);
    repeat (12) @(negedge clk);
    chk("R7 pulse count", pcount, 32'd4);
    rd(3'd3, rv);
    chk("R7 done reads one", rv, 32'h1);
    rd(3'd0, rv);
    chk("R8 mode init after extra clocks", rv & 32'h7, 32'd3);
    wr(3'd3, 32'h1);
    rd(3'd3, rv);
    chk("R7 done cleared", rv, 32'h0);

    // drive disabled: lines idle, mode frozen, no pulses
    wr(3'd1, 32'h104);
    chk("R9 lines idle when drive off", {30'd0, fab_pull, fab_ce_n}, 32'h1);
    pcount = 0;
    wr(3'd2, 32'd2);
    repeat (8) @(negedge clk);
    chk("R9 no pulses when drive off", pcount, 32'd0);
    rd(3'd0, rv);
    chk("R9 mode unchanged when drive off", rv & 32'h7, 32'd3);

    // climb to user mode
    wr(3'd1, 32'h101);
    pcount = 0;
    wr(3'd2, UCLK);
    repeat (2 * UCLK + 10) @(negedge clk);
    chk("R7 long pulse count", pcount, UCLK);
    rd(3'd0, rv);
    chk("R8 mode user", rv & 32'h7, 32'd4);
    rd(3'd5, rv);
    chk("R8 monitor init-done bit", (rv >> 2) & 32'h1, 32'h1);
    rd(3'd4, rv);
    chk("R10 event latched for init-done edge", rv, 32'h4);

    // restart and inject a fault
    wr(3'd1, 32'h5);
    wr(3'd1, 32'h101);
    rd(3'd0, rv);
    chk("R3 mode back in configuration", rv & 32'h7, 32'd2);
    @(negedge clk) fab_err = 1'b1;
    @(negedge clk) fab_err = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd0, rv);
    chk("R6 mode unknown after fault", rv & 32'h7, 32'd5);
    rd(3'd5, rv);
    chk("R6 monitor status low", rv & 32'h3, 32'h0);
    chk("R6 error output", {30'd0, mon_done, mon_err}, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule